// File: doc/BRIEF.md
# Nibble-Written Bank Controller With Prescaled Interrupt Timer

This block sits on the host write bus of a banked memory system and turns register writes into bank numbers for an address translator. It holds eight 8-bit character bank registers, each filled by two separate 4-bit writes. Two different address-line wirings decode onto the same registers, so both board variants reach every nibble. It also holds two switchable 8 KB program banks, a 2-bit mirroring mode and an 8-bit interrupt timer. A swap mode selects which program window the primary program register drives.

Every write takes effect at the next clock edge, and the bank outputs change there. The interrupt timer counts up on an internal prescaler tick. When it passes 0xFF it reloads from a latch that is written in nibbles, and it raises the interrupt line until software acknowledges it.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset every bank output, the mirroring mode and the interrupt are 0, and swap mode is off.
- R2: A write with address bits 15..12 = 0x8 loads the full data byte into the window-4 bank (`prg_win4`) when swap mode is off, and into the window-6 bank (`prg_win6`) when it is on. A write with bits 15..12 = 0xA always loads `prg_win5`.
- R3: A write to 0x9001 or 0x9004 (bits 11..4 ignored) sets swap mode from data bit 1. If that bit differs from the current swap mode, the stored `prg_win4` and `prg_win6` values exchange places. If it does not differ, both stay unchanged.
- R4: A write to 0x9000 (bits 11..4 ignored) sets `mirror` to data bits 1..0: 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R5: For address bits 15..12 = p in 0xB..0xE, let k = p-0xB. Address bits 3..0 select the target: 0 gives the low nibble of register 2k, 2 or 8 its high nibble, 1 or 4 the low nibble of register 2k+1, and 3 or 0xC its high nibble. Other offsets change nothing, and bits 11..4 are ignored.
- R6: A character nibble write stores only data bits 3..0, keeps the other nibble, and shows on `chr_banks[8i+7:8i]` for register i one cycle after the write.
- R7: Writes to 0xF000 (latch bits 3..0) and to 0xF002 or 0xF008 (latch bits 7..4) store data bits 3..0 and clear the interrupt.
- R8: A write to 0xF001 or 0xF004 sets the enable pair from data bits 1..0, reloads the counter from the latch, restarts the prescaler and clears the interrupt.
- R9: A write to 0xF003 or 0xF00C copies enable bit 0 into both enable bits and clears the interrupt.
- R10: While enable bit 1 is set, the counter advances once every TICK_DIV cycles. The interrupt first rises TICK_DIV*(256-latch) cycles after the enable write. It stays high through later overflows until an acknowledging write, and the acknowledge wins when both fall on the same edge.
- R11: While enable bit 1 is clear, the counter holds and the interrupt never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| prg_win4 | output | 8 | Bank number for program window 4 |
| prg_win5 | output | 8 | Bank number for program window 5 |
| prg_win6 | output | 8 | Bank number for program window 6 |
| chr_banks | output | 64 | Eight 8-bit character bank numbers, register i in bits 8i+7..8i |
| mirror | output | 2 | Mirroring mode |
| irq | output | 1 | Interrupt request, high until acknowledged |

## Verification
The character registers receive random nibble writes over all sixteen low-offset values, with random bits 11..4. This separates the two aliased wirings, the ignored offsets and the nibble-preserving merge. Program writes are shuffled at random with mode writes that both toggle and repeat the swap bit, which tells an exchange of stored values apart from a simple remap. Directed timer cases with different latch values and enable pairs pin down the first-interrupt cycle count, the hold through later overflows, each acknowledge address and the stopped state.

// File: rtl/nbc_pkg.sv
// Shared types for the nibble-written bank controller.
package nbc_pkg;
    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_t;

    // One-cycle write strobes produced by the address decoder.
    typedef struct packed {
        logic       prg_main;   // 0x8xxx
        logic       prg_mid;    // 0xAxxx
        logic       mir_set;    // 0x9000
        logic       mode_set;   // 0x9001 / 0x9004
        logic       lat_lo;     // 0xF000
        logic       lat_hi;     // 0xF002 / 0xF008
        logic       en_load;    // 0xF001 / 0xF004
        logic       en_copy;    // 0xF003 / 0xF00C
        logic [7:0] chr_lo;     // per-register low-nibble strobe
        logic [7:0] chr_hi;     // per-register high-nibble strobe
    } wr_strobe_t;
endpackage

// File: rtl/nbc_decode.sv
// Address decoder: turns one bus write into a set of one-hot strobes.
// Assumes one write per cycle; only address bits 15..12 and 3..0 are used,
// except the program-bank pages, which use bits 15..12 alone.
module nbc_decode
    import nbc_pkg::*;
(
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    output wr_strobe_t  stb
);
    logic [3:0] page;
    logic [3:0] ofs;
    logic [1:0] pair;

    assign page = wr_addr[15:12];
    assign ofs  = wr_addr[3:0];
    assign pair = 2'(page - 4'hB);

    // Decode page and offset into strobes.
    always_comb begin
        stb = '0;
        if (wr_en) begin
            unique case (page)
                4'h8: stb.prg_main = 1'b1;
                4'hA: stb.prg_mid  = 1'b1;
                4'h9: begin
                    stb.mir_set  = (ofs == 4'h0);
                    stb.mode_set = (ofs == 4'h1) || (ofs == 4'h4);
                end
                4'hB, 4'hC, 4'hD, 4'hE: begin
                    case (ofs)
                        4'h0:       stb.chr_lo[{pair, 1'b0}] = 1'b1;
                        4'h2, 4'h8: stb.chr_hi[{pair, 1'b0}] = 1'b1;
                        4'h1, 4'h4: stb.chr_lo[{pair, 1'b1}] = 1'b1;
                        4'h3, 4'hC: stb.chr_hi[{pair, 1'b1}] = 1'b1;
                        default:    ;
                    endcase
                end
                4'hF: begin
                    stb.lat_lo  = (ofs == 4'h0);
                    stb.lat_hi  = (ofs == 4'h2) || (ofs == 4'h8);
                    stb.en_load = (ofs == 4'h1) || (ofs == 4'h4);
                    stb.en_copy = (ofs == 4'h3) || (ofs == 4'hC);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nbc_chr_regs.sv
// Character bank register file: NUM_CHR registers, each loaded one nibble
// at a time. Assumes at most one strobe per register per cycle.
module nbc_chr_regs #(
    parameter int NUM_CHR = 8,
    parameter int BANK_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CHR-1:0]        lo_we,
    input  logic [NUM_CHR-1:0]        hi_we,
    input  logic [3:0]                nib,
    output logic [NUM_CHR*BANK_W-1:0] banks
);
    localparam int HALF = BANK_W / 2;

    for (genvar i = 0; i < NUM_CHR; i++) begin : g_reg
        logic [BANK_W-1:0] val;
        // Merge the written nibble into register i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= '0;
            else if (lo_we[i])
                val[HALF-1:0] <= nib[HALF-1:0];
            else if (hi_we[i])
                val[BANK_W-1:HALF] <= nib[HALF-1:0];
        end
        assign banks[i*BANK_W +: BANK_W] = val;
    end
endmodule

// File: rtl/nbc_prg_regs.sv
// Program bank and mirroring registers. Swap mode steers the primary
// program write to window 6; toggling it exchanges the stored window-4 and
// window-6 values, so the outputs need no steering mux.
module nbc_prg_regs
    import nbc_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        stb,
    input  logic [7:0]        data,
    output logic [BANK_W-1:0] win4,
    output logic [BANK_W-1:0] win5,
    output logic [BANK_W-1:0] win6,
    output mirror_t           mir
);
    logic swap_on;

    // Program windows and swap state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win4    <= '0;
            win5    <= '0;
            win6    <= '0;
            swap_on <= 1'b0;
        end else begin
            if (stb.prg_main) begin
                if (swap_on) win6 <= BANK_W'(data);
                else         win4 <= BANK_W'(data);
            end
            if (stb.prg_mid)
                win5 <= BANK_W'(data);
            if (stb.mode_set) begin
                swap_on <= data[1];
                if (data[1] != swap_on) begin
                    win4 <= win6;
                    win6 <= win4;
                end
            end
        end
    end

    // Mirroring mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mir <= MIR_VERT;
        else if (stb.mir_set)
            mir <= mirror_t'(data[1:0]);
    end
endmodule

// File: rtl/nbc_irq_timer.sv
// Interrupt timer: nibble-written latch, two-bit enable, prescaler that
// ticks every TICK_DIV cycles while enable bit 1 is set, up-counter that
// reloads from the latch past 0xFF. Acknowledge beats a same-edge overflow.
module nbc_irq_timer
    import nbc_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wr_strobe_t stb,
    input  logic [7:0] data,
    output logic       run,
    output logic       irq
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;

    logic [CNT_W-1:0] latch;
    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] pre;
    logic [1:0]       en;
    logic             tick;
    logic             wrap;
    logic             ack;

    assign run  = en[1];
    assign tick = en[1] && !stb.en_load && (pre == PRE_LAST);
    assign wrap = tick && (cnt == CNT_TOP);
    assign ack  = stb.lat_lo | stb.lat_hi | stb.en_load | stb.en_copy;

    // Latch nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch <= '0;
        else if (stb.lat_lo)
            latch[3:0] <= data[3:0];
        else if (stb.lat_hi)
            latch[7:4] <= data[3:0];
    end

    // Enable pair, prescaler and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 2'b00;
            pre <= '0;
            cnt <= '0;
        end else if (stb.en_load) begin
            en  <= data[1:0];
            pre <= '0;
            cnt <= latch;
        end else begin
            if (stb.en_copy)
                en <= {en[0], en[0]};
            if (en[1]) begin
                pre <= tick ? '0 : pre + 1'b1;
                if (tick)
                    cnt <= wrap ? latch : cnt + 1'b1;
            end
        end
    end

    // Interrupt flag: set on wrap, cleared by any acknowledging write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (ack)
            irq <= 1'b0;
        else if (wrap)
            irq <= 1'b1;
    end
endmodule

// File: rtl/nibble_bank_ctrl.sv
// Top level: decoder, character registers, program/mirroring registers and
// interrupt timer. All state updates on the write's clock edge.
module nibble_bank_ctrl
    import nbc_pkg::*;
#(
    parameter int NUM_CHR  = 8,
    parameter int BANK_W   = 8,
    parameter int TICK_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [15:0]               wr_addr,
    input  logic [7:0]                wr_data,
    output logic [BANK_W-1:0]         prg_win4,
    output logic [BANK_W-1:0]         prg_win5,
    output logic [BANK_W-1:0]         prg_win6,
    output logic [NUM_CHR*BANK_W-1:0] chr_banks,
    output logic [1:0]                mirror,
    output logic                      irq
);
    wr_strobe_t stb;
    mirror_t    mir;
    logic       irq_run;

    nbc_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .stb     (stb)
    );

    nbc_chr_regs #(.NUM_CHR(NUM_CHR), .BANK_W(BANK_W)) u_chr (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (stb.chr_lo[NUM_CHR-1:0]),
        .hi_we (stb.chr_hi[NUM_CHR-1:0]),
        .nib   (wr_data[3:0]),
        .banks (chr_banks)
    );

    nbc_prg_regs #(.BANK_W(BANK_W)) u_prg (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .data  (wr_data),
        .win4  (prg_win4),
        .win5  (prg_win5),
        .win6  (prg_win6),
        .mir   (mir)
    );

    nbc_irq_timer #(.TICK_DIV(TICK_DIV)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .data  (wr_data),
        .run   (irq_run),
        .irq   (irq)
    );

    assign mirror = mir;
endmodule

// File: rtl/nbc_checker.sv
// Property checker for nibble_bank_ctrl, attached through bind.
module nbc_checker #(
    parameter int NUM_CHR = 8,
    parameter int BANK_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [15:0]               wr_addr,
    input logic [7:0]                wr_data,
    input logic [BANK_W-1:0]         prg_win5,
    input logic [NUM_CHR*BANK_W-1:0] chr_banks,
    input logic [1:0]                mirror,
    input logic                      irq,
    input logic                      irq_run
);
    // R4: mirroring follows data bits 1..0 of a 0x9000 write
    a_r4_mirror_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h9 && wr_addr[3:0] == 4'h0)
        |=> mirror == $past(wr_data[1:0]));

    // R2: page 0xA always loads window 5
    a_r2_win5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hA) |=> prg_win5 == $past(wr_data));

    // R6: register 0 low nibble write keeps its high nibble
    a_r6_nibble_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hB && wr_addr[3:0] == 4'h0)
        |=> (chr_banks[3:0] == $past(wr_data[3:0]))
            && (chr_banks[7:4] == $past(chr_banks[7:4])));

    // R7: a latch low-nibble write clears the interrupt
    a_r7_latch_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hF && wr_addr[3:0] == 4'h0) |=> !irq);

    // R11: the interrupt only rises while the counter runs
    a_r11_no_rise_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_run));
endmodule

bind nibble_bank_ctrl nbc_checker #(.NUM_CHR(NUM_CHR), .BANK_W(BANK_W)) u_nbc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prg_win5  (prg_win5),
    .chr_banks (chr_banks),
    .mirror    (mirror),
    .irq       (irq),
    .irq_run   (irq_run)
);

// File: tb/test_nibble_bank_ctrl.sv
module test_nibble_bank_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  prg_win4, prg_win5, prg_win6;
    logic [63:0] chr_banks;
    logic [1:0]  mirror;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_chr [8];
    logic [7:0] m_w4, m_w5, m_w6;
    logic [1:0] m_mir;
    logic       m_swap;

    always #4 clk = ~clk;

    nibble_bank_ctrl #(.TICK_DIV(DIV)) i_nibble_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prg_win4(prg_win4), .prg_win5(prg_win5),
        .prg_win6(prg_win6), .chr_banks(chr_banks), .mirror(mirror), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus write; returns at the negedge right after the write edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [63:0] chr_model();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_chr[i];
        return v;
    endfunction

    // Apply a character write to the model (R5 decode, R6 merge).
    function automatic void chr_apply(input logic [3:0] pg, input logic [3:0] of, input logic [3:0] n);
        int k = 2 * (int'(pg) - 11);
        case (of)
            4'h0:       m_chr[k][3:0]   = n;
            4'h2, 4'h8: m_chr[k][7:4]   = n;
            4'h1, 4'h4: m_chr[k+1][3:0] = n;
            4'h3, 4'hC: m_chr[k+1][7:4] = n;
            default: ;
        endcase
    endfunction

    // Count cycles from now until irq is seen high.
    task automatic wait_irq(output int n, input int limit);
        n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) m_chr[i] = '0;
        m_w4 = 0; m_w5 = 0; m_w6 = 0; m_mir = 0; m_swap = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 chr", chr_banks, 64'h0);
        check("R1 prg", {prg_win4, prg_win5, prg_win6}, 24'h0);
        check("R1 mirror/irq", {mirror, irq}, 3'b000);

        // R5/R6 directed: both wirings for register 2 (page C)
        wr(16'hC000, 8'hF5); chr_apply(4'hC, 4'h0, 4'h5);
        wr(16'hC008, 8'hA3); chr_apply(4'hC, 4'h8, 4'h3);
        check("R6 upper data bits ignored", chr_banks, chr_model());
        wr(16'hC7F2, 8'h09); chr_apply(4'hC, 4'h2, 4'h9);
        check("R5 alias offset 2 with bits 11..4 set", chr_banks[23:16], 8'h95);
        wr(16'hC006, 8'h0E);
        check("R5 unlisted offset ignored", chr_banks, chr_model());

        // R5/R6 random
        for (int i = 0; i < 300; i++) begin
            logic [3:0] pg = 4'hB + 4'($urandom_range(0, 3));
            logic [3:0] of = 4'($urandom_range(0, 15));
            logic [7:0] d  = 8'($urandom);
            logic [15:0] a = {pg, 8'($urandom), of};
            wr(a, d);
            chr_apply(pg, of, d[3:0]);
            check("R5 R6 random chr write", chr_banks, chr_model());
        end

        // R3 directed: swap toggle exchanges, repeat leaves alone
        wr(16'h8000, 8'h11); m_w4 = 8'h11;
        wr(16'hA000, 8'h22); m_w5 = 8'h22;
        wr(16'h9001, 8'h02); {m_w4, m_w6} = {m_w6, m_w4}; m_swap = 1;
        check("R3 swap exchanges", {prg_win4, prg_win6}, {8'h00, 8'h11});
        wr(16'h8123, 8'h33); m_w6 = 8'h33;
        check("R2 swap mode loads window 6", {prg_win4, prg_win5, prg_win6}, {8'h00, 8'h22, 8'h33});
        wr(16'h9004, 8'h02);
        check("R3 same bit no exchange", {prg_win4, prg_win6}, {8'h00, 8'h33});

        // R2/R3/R4 random
        for (int i = 0; i < 300; i++) begin
            logic [7:0] d = 8'($urandom);
            int sel = $urandom_range(0, 3);
            case (sel)
                0: begin
                    wr({4'h8, 12'($urandom)}, d);
                    if (m_swap) m_w6 = d; else m_w4 = d;
                end
                1: begin wr({4'hA, 12'($urandom)}, d); m_w5 = d; end
                2: begin
                    wr({4'h9, 8'($urandom), ($urandom_range(0, 1) != 0) ? 4'h1 : 4'h4}, d);
                    if (d[1] != m_swap) {m_w4, m_w6} = {m_w6, m_w4};
                    m_swap = d[1];
                end
                default: begin wr({4'h9, 8'($urandom), 4'h0}, d); m_mir = d[1:0]; end
            endcase
            check("R2 R3 R4 random prg/mode/mirror",
                  {prg_win4, prg_win5, prg_win6, mirror},
                  {m_w4, m_w5, m_w6, m_mir});
        end
        wr(16'h9000, 8'hFF);
        check("R4 single-screen high", mirror, 2'd3);

        // R7/R8/R10: latch 0xF0, run only
        wr(16'hF000, 8'hF0);
        wr(16'hF008, 8'hAF);
        wr(16'hF001, 8'h02);
        wait_irq(n, 5000);
        check("R10 first irq cycle latch F0", n, DIV * (256 - 8'hF0));
        repeat (100) @(negedge clk);
        check("R10 irq held across overflows", irq, 1'b1);
        // R9: copy bit 0 (=0) stops and acks
        wr(16'hF00C, 8'h00);
        check("R9 copy acks", irq, 1'b0);
        repeat (2000) @(negedge clk);
        check("R11 stopped counter no irq", irq, 1'b0);

        // R8 with latch FE via high-nibble alias F002
        wr(16'hF000, 8'h0E);
        wr(16'hF002, 8'h0F);
        wr(16'hF004, 8'h03);
        check("R8 enable write acks", irq, 1'b0);
        wait_irq(n, 5000);
        check("R10 first irq cycle latch FE", n, DIV * 2);
        wr(16'hF002, 8'h0F);
        check("R7 high latch write acks", irq, 1'b0);
        // R9: copy with bit 0 = 1 keeps running
        wr(16'hF003, 8'h00);
        check("R9 copy acks", irq, 1'b0);
        wait_irq(n, 2000);
        check("R9 copy of bit 0 keeps counting", irq, 1'b1);
        wr(16'hF000, 8'h0E);
        check("R7 low latch write acks", irq, 1'b0);

        // R10 latch 0: full 256-tick period
        wr(16'hF000, 8'h00);
        wr(16'hF008, 8'h00);
        wr(16'hF001, 8'h02);
        wait_irq(n, 5000);
        check("R10 first irq cycle latch 00", n, DIV * 256);

        // R11: enable pair 01 never counts
        wr(16'hF001, 8'h01);
        repeat (1200) @(negedge clk);
        check("R11 bit1 clear no irq", irq, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule